// File: doc/BRIEF.md
# Nibble-command register access decoder

This block sits behind a host byte link and turns a stream of 8-bit command bytes into register accesses. The upper four bits of every byte select an operation and the lower four bits carry its operand. Eight-bit register addresses and write data are assembled from two nibble-sized operands each. A write is committed when the high data nibble arrives. A read command returns one byte on a response channel one cycle later.

The address register can step by one after a write commit or a read, either upward or downward, and it wraps modulo 256. This lets a host sweep a bank of registers with one command byte per access.

Each address reaches two independent stores:
- Writes land in a write-side register file, which drives `wr_regs_o`.
- Reads sample a read-side vector, `rd_regs_i`, that the surrounding logic supplies.

Only the lowest `NUM_REGS` addresses are implemented.

Top module: `nibcmd_regif`

## Requirements
- R1: After reset the address register, the low data latch and every write-side register are zero, and `rsp_valid_o` is low.
- R2: A command with upper nibble 0x0 loads its operand into address bits [3:0]. Upper nibble 0x1 loads it into address bits [7:4]. The other address nibble keeps its value.
- R3: Upper nibble 0x2 stores its operand in the low data latch. Upper nibble 0x3 writes the byte {operand, latch} to the write-side register at the current address, and the result appears on `wr_regs_o` after the accepting clock edge. The latch keeps its value after a commit.
- R4: Upper nibble 0x4 makes `rsp_valid_o` high for exactly the next cycle. In that cycle `rsp_byte_o` holds byte [8*a+7:8*a] of `rd_regs_i`, where a is the address before any step.
- R5: For opcodes 0x3 and 0x4, operand bit 0 set moves the address by one after the access. Operand bit 1 picks the direction: 1 means minus one, 0 means plus one. The step wraps modulo 256. With bit 0 clear the address does not move.
- R6: A read from an address at or above `NUM_REGS` (16 by default) returns 0xFF. A write commit to such an address changes no write-side register.
- R7: A write to an address does not change what a read of that address returns. Reads always reflect `rd_regs_i`.
- R8: Commands with upper nibble 0x5 through 0xF change neither the address, nor the data latch, nor any write-side register, and produce no response.
- R9: A byte presented while `cmd_valid_i` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command byte present this cycle |
| cmd_byte_i | input | 8 | Command: opcode [7:4], operand [3:0] |
| rd_regs_i | input | NUM_REGS*8 | Read-side register values, register a at bits [8a+7:8a] |
| wr_regs_o | output | NUM_REGS*8 | Write-side register file contents, same packing |
| rsp_valid_o | output | 1 | Read response present this cycle |
| rsp_byte_o | output | 8 | Read response byte |

## Verification
The bench sweeps all 256 addresses with auto-increment reads. This catches a design that mis-decodes the implemented range, whose reads from 0x10 and up would return stale register data instead of 0xFF, or one that saturates at 0xFF instead of wrapping to zero. Decrement sweeps across zero target a design that reads the direction bit inverted, or that steps even when the enable bit is clear. For opcode 0x3 the operand serves both as the high data nibble and as the step control. A design that decouples the two, or that clears the low data latch on commit, writes the wrong byte or leaves the address in the wrong place. Each unhandled opcode is followed by a commit and a read, so that a design that lets them touch the latches or the address shows a mismatch at the ports.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;
  localparam logic [3:0] OP_ADDR_LO = 4'h0;
  localparam logic [3:0] OP_ADDR_HI = 4'h1;
  localparam logic [3:0] OP_DATA_LO = 4'h2;
  localparam logic [3:0] OP_COMMIT  = 4'h3;
  localparam logic [3:0] OP_READ    = 4'h4;
  localparam int STEP_EN_BIT = 0;
  localparam int STEP_DN_BIT = 1;

  typedef struct packed {
    logic       ld_lo;
    logic       ld_hi;
    logic       dat_lo;
    logic       commit;
    logic       rd;
    logic       step;
    logic       down;
    logic [3:0] arg;
  } dec_t;
endpackage

// File: rtl/nibcmd_decode.sv
module nibcmd_decode
  import nibcmd_pkg::*;
(
  input  logic       valid_i,
  input  logic [7:0] byte_i,
  output dec_t       dec_o
);
  logic [3:0] op;
  assign op = byte_i[7:4];

  always_comb begin
    dec_o        = '0;
    dec_o.arg    = byte_i[3:0];
    if (valid_i) begin
      dec_o.ld_lo  = (op == OP_ADDR_LO);
      dec_o.ld_hi  = (op == OP_ADDR_HI);
      dec_o.dat_lo = (op == OP_DATA_LO);
      dec_o.commit = (op == OP_COMMIT);
      dec_o.rd     = (op == OP_READ);
    end
    dec_o.step = (dec_o.commit | dec_o.rd) & byte_i[STEP_EN_BIT];
    dec_o.down = byte_i[STEP_DN_BIT];
  end
endmodule

// File: rtl/nibcmd_addr.sv
module nibcmd_addr #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_lo_i,
  input  logic          ld_hi_i,
  input  logic [3:0]    arg_i,
  input  logic          step_i,
  input  logic          down_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] ONE = AW'(1);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (ld_lo_i)  addr_q[3:0] <= arg_i;
    else if (ld_hi_i)  addr_q[7:4] <= arg_i;
    else if (step_i)   addr_q <= down_i ? addr_q - ONE : addr_q + ONE;
  end

  assign addr_o = addr_q;

  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_lo_i && !ld_hi_i) |=>
      (addr_q == ($past(down_i) ? $past(addr_q) - ONE : $past(addr_q) + ONE)));
  // R8
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !ld_lo_i && !ld_hi_i) |=> $stable(addr_q));
endmodule

// File: rtl/nibcmd_wfile.sv
module nibcmd_wfile #(
  parameter int NUM_REGS = 16,
  parameter int AW       = 8,
  parameter int DW       = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q <= '0;
      else if (we_i && addr_i == AW'(g))            q <= wdata_i;
    end
    assign regs_o[g*DW +: DW] = q;
  end

  // R6
  wr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ({1'b0, addr_i} >= (AW+1)'(NUM_REGS))) |=> $stable(regs_o));
  // R8
  wr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_o));
endmodule

// File: rtl/nibcmd_regif.sv
module nibcmd_regif
  import nibcmd_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [7:0]            cmd_byte_i,
  input  logic [NUM_REGS*8-1:0] rd_regs_i,
  output logic [NUM_REGS*8-1:0] wr_regs_o,
  output logic                  rsp_valid_o,
  output logic [7:0]            rsp_byte_o
);
  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int IDXW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [AW:0] LIMIT = (AW+1)'(NUM_REGS);

  dec_t          dec;
  logic [AW-1:0] addr;
  logic [3:0]    dlo_q;
  logic          in_range;
  logic [DW-1:0] rd_sel;
  logic [DW-1:0] rd_arr [NUM_REGS];

  nibcmd_decode u_dec (.valid_i(cmd_valid_i), .byte_i(cmd_byte_i), .dec_o(dec));

  nibcmd_addr #(.AW(AW)) u_addr (
    .clk_i, .rst_ni,
    .ld_lo_i(dec.ld_lo), .ld_hi_i(dec.ld_hi), .arg_i(dec.arg),
    .step_i(dec.step), .down_i(dec.down), .addr_o(addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         dlo_q <= '0;
    else if (dec.dat_lo) dlo_q <= dec.arg;
  end

  nibcmd_wfile #(.NUM_REGS(NUM_REGS), .AW(AW), .DW(DW)) u_wfile (
    .clk_i, .rst_ni,
    .we_i(dec.commit), .addr_i(addr), .wdata_i({dec.arg, dlo_q}),
    .regs_o(wr_regs_o)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_rd
    assign rd_arr[g] = rd_regs_i[g*DW +: DW];
  end

  assign in_range = {1'b0, addr} < LIMIT;
  assign rd_sel   = in_range ? rd_arr[addr[IDXW-1:0]] : 8'hFF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_byte_o  <= '0;
    end else begin
      rsp_valid_o <= dec.rd;
      if (dec.rd) rsp_byte_o <= rd_sel;
    end
  end

  // R6
  rd_oob_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.rd && !in_range) |=> (rsp_valid_o && rsp_byte_o == 8'hFF));
  // R8
  dec_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dec.ld_lo, dec.ld_hi, dec.dat_lo, dec.commit, dec.rd}));
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> (!rsp_valid_o && $stable(wr_regs_o)));
endmodule

// File: tb/nibcmd_regif_test.sv
module nibcmd_regif_test;
  localparam int N = 16;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           cmd_valid = 1'b0;
  logic [7:0]     cmd_byte = '0;
  logic [N*8-1:0] rd_regs;
  logic [N*8-1:0] wr_regs;
  logic           rsp_valid;
  logic [7:0]     rsp_byte;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_addr;
  logic [3:0] m_dlo;
  logic [7:0] m_wr [N];

  always #10 clk = ~clk;

  nibcmd_regif #(.NUM_REGS(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_byte_i(cmd_byte),
    .rd_regs_i(rd_regs), .wr_regs_o(wr_regs), .rsp_valid_o(rsp_valid), .rsp_byte_o(rsp_byte)
  );

  function automatic logic [7:0] rd_val(input int a);
    return 8'((a * 29 + 91) & 255);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    return (a < 8'(N)) ? rd_val(int'(a)) : 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_wr(input string req);
    for (int i = 0; i < N; i++) chk(req, 32'(wr_regs[i*8 +: 8]), 32'(m_wr[i]));
  endtask

  // Send one command; model it; check the response flag and byte.
  task automatic send(input logic [7:0] b, input string req);
    logic [7:0] exp_b;
    logic       is_rd;
    is_rd = (b[7:4] == 4'h4);
    exp_b = exp_rd(m_addr);
    cmd_byte  = b;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    case (b[7:4])
      4'h0: m_addr[3:0] = b[3:0];
      4'h1: m_addr[7:4] = b[3:0];
      4'h2: m_dlo = b[3:0];
      4'h3: if (m_addr < 8'(N)) m_wr[m_addr[3:0]] = {b[3:0], m_dlo};
      default: ;
    endcase
    if ((b[7:4] == 4'h3 || is_rd) && b[0]) m_addr = b[1] ? m_addr - 8'd1 : m_addr + 8'd1;
    chk(req, 32'(rsp_valid), 32'(is_rd));
    if (is_rd) chk(req, 32'(rsp_byte), 32'(exp_b));
  endtask

  task automatic set_addr(input logic [7:0] a);
    send({4'h0, a[3:0]}, "R2");
    send({4'h1, a[7:4]}, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) rd_regs[i*8 +: 8] = rd_val(i);
    m_addr = '0;
    m_dlo  = '0;
    for (int i = 0; i < N; i++) m_wr[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", 32'(rsp_valid), 0);
    chk_wr("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: data latch and address start at zero
    send(8'h3C, "R1");
    chk("R1", 32'(wr_regs[7:0]), 32'h0C0);
    send(8'h40, "R1");

    // R3 R2: write sweep of all registers, explicit addressing
    for (int i = 0; i < N; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 5) & 255);
      set_addr(8'(i));
      send({4'h2, v[3:0]}, "R3");
      send({4'h3, v[7:4]}, "R3");
    end
    chk_wr("R3");

    // R5 R6 R4: full increment read sweep, wrap to zero
    set_addr(8'h00);
    for (int i = 0; i < 256; i++) send(8'h41, "R5_R6");
    chk("R5", 32'(m_addr), 0);
    send(8'h40, "R5");
    send(8'h40, "R4");

    // R5: decrement across zero
    for (int i = 0; i < 24; i++) send(8'h43, "R5");
    // R5: direction bit without enable does not move
    set_addr(8'h09);
    send(8'h42, "R5");
    send(8'h42, "R5");
    send(8'h40, "R5");

    // R5 R3: commit operand also steers the step; latch persists
    set_addr(8'h03);
    send(8'h26, "R3");
    send(8'h31, "R5");
    send(8'h40, "R5");
    send(8'h33, "R3");
    send(8'h40, "R5");
    chk_wr("R3");
    set_addr(8'h00);
    send(8'h3F, "R5");
    send(8'h40, "R5");
    chk("R5", 32'(m_addr), 32'hFF);

    // R7: a write does not alter the read-side value
    set_addr(8'h07);
    send(8'h23, "R7");
    send(8'h3C, "R7");
    chk("R7", 32'(wr_regs[7*8 +: 8]), 32'hC3);
    send(8'h40, "R7");

    // R6: writes above the implemented range change nothing
    for (int a = 16; a < 256; a += 17) begin
      set_addr(8'(a));
      send(8'h2A, "R6");
      send(8'h3C, "R6");
      chk_wr("R6");
    end

    // R8: unhandled opcodes leave address, latch and registers alone
    set_addr(8'h05);
    send(8'h29, "R8");
    for (int op = 5; op < 16; op++) begin
      send({4'(op), 4'hF}, "R8");
      send({4'(op), 4'h1}, "R8");
    end
    chk_wr("R8");
    send(8'h40, "R8");
    send(8'h30, "R8");
    chk("R8", 32'(wr_regs[5*8 +: 8]), 32'h09);

    // R9: bytes without valid are ignored
    set_addr(8'h02);
    cmd_byte = 8'h41;
    repeat (3) begin
      @(negedge clk);
      chk("R9", 32'(rsp_valid), 0);
    end
    cmd_byte = 8'h3F;
    @(negedge clk);
    chk_wr("R9");
    send(8'h40, "R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule